// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block is the interrupt front end for a small 8-bit controller. It watches one dedicated interrupt pin and six general pin-change inputs, and it turns activity on them into two request lines for the core: one for the dedicated pin and one shared by the pin-change group. Every input first passes through a two-flop synchronizer. The block then compares each synchronized value with its value one cycle earlier to find edges and changes.

The dedicated pin has four sense modes, chosen by a 2-bit code. The low-level mode has no memory: its request follows the synchronized pin for as long as the pin stays low. The three edge modes (any change, falling, rising) set a sticky flag. The pin-change path ORs the changes seen on the inputs that its per-input mask selects, and it has a sticky flag of its own. A flag is set whether or not its request is enabled. The core clears it with a one-cycle acknowledge pulse. A request leaves the block only while its own enable bit and the global interrupt-enable input are both 1. The detection path has no notion of pin direction, so a pin that the chip drives as an output still produces requests.

Software reaches three byte registers through a simple port. Writes take effect on the clock edge. Reads are combinational.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, all three registers read 0x00 and both request outputs are 0.
- R2: Register map: address 0 holds the sense code in bits 1:0; address 1 holds the pin enable in bit 6 and the pin-change enable in bit 5; address 2 holds the six-input change mask in bits 5:0. Every other bit, and all of address 3, reads 0 and ignores writes.
- R3: With sense code 00 (low level), req_pin equals NOT of the synchronized pin, gated by R7, and holds no state. A pin change driven just after a clock edge shows on req_pin after the second edge that follows. In this mode the pin sets no flag.
- R4: With sense code 01 (any change), a pin transition sets the pin flag. req_pin then rises after the third clock edge that follows the transition.
- R5: With sense code 10 only a falling transition sets the pin flag. With sense code 11 only a rising transition sets it.
- R6: In an edge mode, a pulse that stays stable for two clock periods is always caught.
- R7: req_pin is (pin enable AND gie AND the mode's condition). req_chg is (pin-change enable AND gie AND the pin-change flag). Flags are set even while these gates are 0, so the request appears as soon as the gates open.
- R8: A one-cycle pulse on ack_pin clears the pin flag at the next edge. If a new pin event is present in that same cycle, the flag stays set.
- R9: A transition on any pin-change input whose mask bit is 1 sets the pin-change flag. Transitions on inputs whose mask bit is 0 are ignored.
- R10: A one-cycle pulse on ack_chg clears the pin-change flag at the next edge. If a pin-change event is present in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 1 | Dedicated interrupt pin (asynchronous) |
| chg_pins | input | 6 | Pin-change inputs (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| ack_pin | input | 1 | Acknowledge pulse for the pin flag |
| ack_chg | input | 1 | Acknowledge pulse for the pin-change flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| req_pin | output | 1 | Dedicated-pin interrupt request |
| req_chg | output | 1 | Pin-change interrupt request |

## Verification
The assertions assume that gie, the acknowledges and the register port are synchronous to clk and always carry known values. They also assume that each acknowledge is a pulse the core raises for its own flag. The asynchronous pins are left unconstrained. The stimulus meets these assumptions by driving every input one time unit after a rising edge. It raises the acknowledges for single cycles, including a cycle placed on an event in flight. It toggles the pins freely and checks them only after they have passed through the synchronizer.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [1:0] ADDR_SENSE = 2'd0;
  localparam logic [1:0] ADDR_EN    = 2'd1;
  localparam logic [1:0] ADDR_CMASK = 2'd2;

  localparam int EN_PIN_BIT = 6;
  localparam int EN_CHG_BIT = 5;

  // Edge or change event for the dedicated pin; level mode never flags.
  function automatic logic pin_event(sense_e mode, logic cur, logic prev);
    logic ev;
    unique case (mode)
      SENSE_ANY:  ev = cur ^ prev;
      SENSE_FALL: ev = prev & ~cur;
      SENSE_RISE: ev = cur & ~prev;
      default:    ev = 1'b0;
    endcase
    return ev;
  endfunction

  // Level-mode request condition: active while the pin is low.
  function automatic logic level_active(logic cur);
    return ~cur;
  endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/eis_regs.sv
module eis_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_CHG = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [1:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output sense_e             sense_mode,
  output logic               en_pin,
  output logic               en_chg,
  output logic [NUM_CHG-1:0] chg_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_mode <= SENSE_LOW;
      en_pin     <= 1'b0;
      en_chg     <= 1'b0;
      chg_mask   <= '0;
    end else if (we) begin
      unique case (addr)
        ADDR_SENSE: sense_mode <= sense_e'(wdata[1:0]);
        ADDR_EN: begin
          en_pin <= wdata[EN_PIN_BIT];
          en_chg <= wdata[EN_CHG_BIT];
        end
        ADDR_CMASK: chg_mask <= wdata[NUM_CHG-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADDR_SENSE: rdata[1:0] = sense_mode;
      ADDR_EN: begin
        rdata[EN_PIN_BIT] = en_pin;
        rdata[EN_CHG_BIT] = en_chg;
      end
      ADDR_CMASK: rdata[NUM_CHG-1:0] = chg_mask;
      default: ;
    endcase
  end
endmodule

// File: rtl/eis_flag.sv
module eis_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // A set in the same cycle as a clear wins, so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_CHG     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_pin,
  input  logic [NUM_CHG-1:0] chg_pins,
  input  logic               gie,
  input  logic               ack_pin,
  input  logic               ack_chg,
  input  logic               reg_we,
  input  logic [1:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic               req_pin,
  output logic               req_chg
);
  localparam int IN_W = NUM_CHG + 1;

  sense_e             sense_mode;
  logic               en_pin, en_chg;
  logic [NUM_CHG-1:0] chg_mask;

  logic [IN_W-1:0]    in_sync, in_prev;
  logic               pin_s, pin_p;
  logic [NUM_CHG-1:0] chg_s, chg_p;

  logic pin_evt, chg_evt;
  logic pin_flag, chg_flag;

  eis_regs #(.NUM_CHG(NUM_CHG)) u_regs (
    .clk, .rst_n,
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .sense_mode, .en_pin, .en_chg, .chg_mask
  );

  eis_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n, .d({chg_pins, irq_pin}), .q(in_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_prev <= '0;
    else        in_prev <= in_sync;
  end

  assign pin_s = in_sync[0];
  assign pin_p = in_prev[0];
  assign chg_s = in_sync[IN_W-1:1];
  assign chg_p = in_prev[IN_W-1:1];

  assign pin_evt = pin_event(sense_mode, pin_s, pin_p);
  assign chg_evt = |((chg_s ^ chg_p) & chg_mask);

  eis_flag u_pin_flag (
    .clk, .rst_n, .set(pin_evt), .clr(ack_pin), .flag(pin_flag)
  );

  eis_flag u_chg_flag (
    .clk, .rst_n, .set(chg_evt), .clr(ack_chg), .flag(chg_flag)
  );

  always_comb begin
    if (sense_mode == SENSE_LOW) req_pin = gie & en_pin & level_active(pin_s);
    else                         req_pin = gie & en_pin & pin_flag;
  end

  assign req_chg = gie & en_chg & chg_flag;
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       gie,
  input logic       en_pin,
  input logic       ack_pin,
  input logic       ack_chg,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       req_pin,
  input logic       req_chg,
  input logic [1:0] sense_mode,
  input logic       pin_s,
  input logic       pin_evt,
  input logic       chg_evt,
  input logic       pin_flag,
  input logic       chg_flag
);
  // R7
  gate_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pin |-> gie);
  // R7
  gate_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_chg |-> (gie && chg_flag));
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode == 2'b00 && gie && en_pin) |-> (req_pin == !pin_s));
  // R3
  level_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_mode == 2'b00) |-> !pin_evt);
  // R8
  pin_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_evt |=> pin_flag);
  // R8
  pin_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pin && !pin_evt) |=> !pin_flag);
  // R10
  chg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> chg_flag);
  // R10
  chg_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_chg && !chg_evt) |=> !chg_flag);
  // R2
  rsv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[7] == 1'b0 && reg_rdata[4:0] == 5'd0));
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .en_pin(en_pin),
  .ack_pin(ack_pin), .ack_chg(ack_chg),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_pin(req_pin), .req_chg(req_chg),
  .sense_mode(sense_mode), .pin_s(pin_s),
  .pin_evt(pin_evt), .chg_evt(chg_evt),
  .pin_flag(pin_flag), .chg_flag(chg_flag)
);

// File: tb/ext_irq_sense_test.sv
`timescale 1ns/1ps
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin = 1'b0;
  logic [5:0] chg_pins = '0;
  logic       gie = 1'b0, ack_pin = 1'b0, ack_chg = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       req_pin, req_chg;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  ext_irq_sense uut (.*);

  // Behavioural reference state
  int m_mode, m_en_pin, m_en_chg, m_mask;
  int pin_hist[$];
  int chg_hist[$];
  int m_pin_flag, m_chg_flag;

  function automatic int rd_model(int a);
    if (a == 0) return m_mode;
    if (a == 1) return m_en_pin * 64 + m_en_chg * 32;
    if (a == 2) return m_mask;
    return 0;
  endfunction

  function automatic int exp_req_pin();
    int s;
    s = pin_hist[1];
    if (!gie || m_en_pin == 0) return 0;
    if (m_mode == 0) return (s == 0) ? 1 : 0;
    return m_pin_flag;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_en_pin = 0; m_en_chg = 0; m_mask = 0;
      m_pin_flag = 0; m_chg_flag = 0;
      pin_hist = '{0, 0, 0};
      chg_hist = '{0, 0, 0};
    end else begin
      int ps, pp, cs, cp, pev, cev;
      // index 0 = first sync stage, 1 = synced value, 2 = previous synced
      ps = pin_hist[1]; pp = pin_hist[2];
      cs = chg_hist[1]; cp = chg_hist[2];
      pev = 0;
      if (m_mode == 1 && ps != pp) pev = 1;
      if (m_mode == 2 && pp == 1 && ps == 0) pev = 1;
      if (m_mode == 3 && pp == 0 && ps == 1) pev = 1;
      cev = 0;
      for (int i = 0; i < 6; i++)
        if (((m_mask >> i) & 1) && (((cs >> i) & 1) != ((cp >> i) & 1))) cev = 1;
      if (pev) m_pin_flag = 1; else if (ack_pin) m_pin_flag = 0;
      if (cev) m_chg_flag = 1; else if (ack_chg) m_chg_flag = 0;
      if (reg_we) begin
        if (reg_addr == 0) m_mode = reg_wdata & 3;
        if (reg_addr == 1) begin
          m_en_pin = reg_wdata[6];
          m_en_chg = reg_wdata[5];
        end
        if (reg_addr == 2) m_mask = reg_wdata & 8'h3F;
      end
      void'(pin_hist.pop_back());
      pin_hist.push_front(int'(irq_pin));
      void'(chg_hist.pop_back());
      chg_hist.push_front(int'(chg_pins));
    end
  end

  task automatic chk(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(int'(req_pin), exp_req_pin(), cur_req, "req_pin vs model");
      chk(int'(req_chg), (gie && m_en_chg && m_chg_flag) ? 1 : 0, cur_req, "req_chg vs model");
      chk(int'(reg_rdata), rd_model(int'(reg_addr)), cur_req, "rdata vs model");
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, int exp, string req);
    reg_addr = a;
    #0.5;
    chk(int'(reg_rdata), exp, req, "register read");
  endtask

  task automatic clear_pin_flag();
    ack_pin = 1'b1; tick(1); ack_pin = 1'b0; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    cur_req = "R1";
    chk(int'(req_pin), 0, "R1", "req_pin after reset");
    chk(int'(req_chg), 0, "R1", "req_chg after reset");
    rd_chk(2'd0, 0, "R1"); rd_chk(2'd1, 0, "R1"); rd_chk(2'd2, 0, "R1");

    // R2 register map and reserved bits
    cur_req = "R2";
    wr(2'd0, 8'hFF); rd_chk(2'd0, 8'h03, "R2");
    wr(2'd1, 8'hFF); rd_chk(2'd1, 8'h60, "R2");
    wr(2'd2, 8'hFF); rd_chk(2'd2, 8'h3F, "R2");
    wr(2'd3, 8'hFF); rd_chk(2'd3, 8'h00, "R2");
    wr(2'd2, 8'h00);

    // R3 low level, non-latching
    cur_req = "R3";
    wr(2'd0, 8'h00); wr(2'd1, 8'h40); gie = 1'b1;
    irq_pin = 1'b1; tick(3);
    chk(int'(req_pin), 0, "R3", "pin high, level mode");
    irq_pin = 1'b0; tick(3);
    chk(int'(req_pin), 1, "R3", "pin low, level mode");
    irq_pin = 1'b1; tick(3);
    chk(int'(req_pin), 0, "R3", "pin released, no latch");

    // R4 any change
    cur_req = "R4";
    wr(2'd0, 8'h01); clear_pin_flag();
    chk(int'(req_pin), 0, "R4", "flag cleared");
    irq_pin = 1'b0; tick(3);
    chk(int'(req_pin), 1, "R4", "any change sets flag");

    // R5 falling then rising
    cur_req = "R5";
    wr(2'd0, 8'h02); clear_pin_flag();
    irq_pin = 1'b1; tick(4);
    chk(int'(req_pin), 0, "R5", "rising ignored in falling mode");
    irq_pin = 1'b0; tick(4);
    chk(int'(req_pin), 1, "R5", "falling edge caught");
    wr(2'd0, 8'h03); clear_pin_flag();
    irq_pin = 1'b1; tick(4);
    chk(int'(req_pin), 1, "R5", "rising edge caught");
    clear_pin_flag();
    irq_pin = 1'b0; tick(4);
    chk(int'(req_pin), 0, "R5", "falling ignored in rising mode");

    // R6 two-cycle pulse
    cur_req = "R6";
    irq_pin = 1'b1; tick(2); irq_pin = 1'b0; tick(4);
    chk(int'(req_pin), 1, "R6", "two-cycle pulse caught");
    clear_pin_flag();

    // R7 gating, flag set while gated
    cur_req = "R7";
    gie = 1'b0;
    irq_pin = 1'b1; tick(4);
    chk(int'(req_pin), 0, "R7", "gated by gie");
    gie = 1'b1; #0.5;
    chk(int'(req_pin), 1, "R7", "flag held while gated");
    tick(1);
    clear_pin_flag();

    // R8 ack coinciding with an event keeps the flag
    cur_req = "R8";
    wr(2'd0, 8'h01); clear_pin_flag();
    irq_pin = 1'b0; tick(2);
    ack_pin = 1'b1; tick(1); ack_pin = 1'b0;
    chk(int'(req_pin), 1, "R8", "event wins over ack");
    ack_pin = 1'b1; tick(1); ack_pin = 1'b0;
    chk(int'(req_pin), 0, "R8", "ack alone clears");

    // R9 pin-change masking
    cur_req = "R9";
    wr(2'd2, 8'h05); wr(2'd1, 8'h20);
    ack_chg = 1'b1; tick(1); ack_chg = 1'b0; tick(1);
    chg_pins[1] = ~chg_pins[1]; tick(4);
    chk(int'(req_chg), 0, "R9", "unmasked input ignored");
    chg_pins[2] = ~chg_pins[2]; tick(4);
    chk(int'(req_chg), 1, "R9", "masked input change");
    chk(int'(req_pin), 0, "R7", "pin enable off");

    // R10 pin-change acknowledge
    cur_req = "R10";
    ack_chg = 1'b1; tick(1); ack_chg = 1'b0;
    chk(int'(req_chg), 0, "R10", "ack_chg clears");

    // Mixed stimulus against the model (R8 R10 coincidences included)
    cur_req = "mix R5 R8 R9 R10";
    wr(2'd1, 8'h60);
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(3) == 0) irq_pin = ~irq_pin;
      if ($urandom_range(3) == 0) chg_pins = 6'($urandom);
      if ($urandom_range(15) == 0) gie = ~gie;
      ack_pin = ($urandom_range(5) == 0);
      ack_chg = ($urandom_range(5) == 0);
      reg_we = ($urandom_range(19) == 0);
      reg_addr = 2'($urandom);
      reg_wdata = 8'($urandom);
      tick(1);
    end
    reg_we = 1'b0; ack_pin = 1'b0; ack_chg = 1'b0;
    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule